// File: doc/BRIEF.md
# Power Cycling Switch Sequencer

This block drives four power-switch gate enables through a repeating three-state pattern that heats and cools a device under test for junction temperature cycling. Each state holds for its own programmable number of clock ticks. On every change of state, the switches that must open are released at once. The switches that must close follow only after a programmable dead time, so two conducting paths never overlap.

The block also times the measurements. After the new switch pattern is applied and a programmable settling delay has run out, it emits a one-cycle transition strobe. The strobe appears while the new state code is shown, so a logger can tag each sample with its state and never captures the old state's value. A second, free-running strobe fires at a programmable interval for slow long-term logging. A cycle counter and a per-state timer are exposed so that records can be indexed.

Top module: `pwr_cycle_seq`

## Requirements
- R1: The state code is 0 when idle and 1, 2 or 3 when active. Once a state's make phase has begun, the gate outputs are: 4'b0011 in state 1 (bit 0 main, bit 1 bypass), 4'b0101 in state 2 (bit 0 main, bit 2 device under test) and 4'b1000 in state 3 (bit 3 reverse current source). When idle, the gate outputs are 4'b0000.
- R2: States advance 1, 2, 3, 1 and so on. State k lasts max(hold_k, dead_ticks + settle_ticks + 2) cycles, so a short hold is stretched until the transition strobe has been issued.
- R3: For the first dead_ticks + 1 cycles of a state, the gate output is the bitwise AND of the old and new patterns. From state timer value dead_ticks + 1 onward, it is the new pattern. No cycle both opens one switch and closes another.
- R4: In each state, `xsamp` is high for exactly one cycle, at state timer value dead_ticks + 1 + settle_ticks, and the state code shown in that cycle is the new state.
- R5: `cycle_cnt` is 0 when idle. It becomes 1 on the first entry to state 1 and increases by one on each later entry to state 1.
- R6: `state_timer` is 0 in the first cycle of every state and increases by one each cycle while the state lasts.
- R7: While active, `psamp` is high every max(period_ticks, 1) cycles, first in cycle period_ticks - 1 counted from the first active cycle. A period of 0 or 1 gives a strobe every cycle.
- R8: While `rst_n` is low, and in the cycle after `en` was sampled low, all gate outputs, the state code, the cycle counter, the timer and both strobes are 0. One cycle after `en` is sampled high in idle, the block is in state 1 with timer 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low forces idle |
| hold1 | input | TW | Hold time of state 1 in cycles |
| hold2 | input | TW | Hold time of state 2 in cycles |
| hold3 | input | TW | Hold time of state 3 in cycles |
| dead_ticks | input | DW | Break-to-make dead time minus one |
| settle_ticks | input | DW | Cycles from make to transition strobe |
| period_ticks | input | TW | Interval of the periodic strobe |
| gate | output | 4 | Switch enables: main, bypass, DUT, current source |
| state_code | output | 2 | Current state, 0 when idle |
| cycle_cnt | output | CW | Completed-entry count of state 1 |
| state_timer | output | TW | Cycles since entry to the current state |
| xsamp | output | 1 | One-cycle post-transition sample strobe |
| psamp | output | 1 | Periodic sample strobe |

## Verification
All outputs come from registers through combinational decode only. A change of `en` is therefore visible one cycle later, and within a state each event falls at a fixed timer value: the make at dead_ticks + 1 and the strobe at dead_ticks + 1 + settle_ticks. The bench drives inputs on the falling edge and samples on the falling edge. It counts falling edges from the first sample in which state 1 appears and compares each event's offset and each state's length with values worked out from the requirements. Periodic strobes are tallied over one full 1-2-3 round and compared with the round length divided by the period.

// File: rtl/pwr_cycle_seq.sv
module pwr_cycle_seq #(
  parameter int TW = 32,
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [TW-1:0] hold1,
  input  logic [TW-1:0] hold2,
  input  logic [TW-1:0] hold3,
  input  logic [DW-1:0] dead_ticks,
  input  logic [DW-1:0] settle_ticks,
  input  logic [TW-1:0] period_ticks,
  output logic [3:0]    gate,
  output logic [1:0]    state_code,
  output logic [CW-1:0] cycle_cnt,
  output logic [TW-1:0] state_timer,
  output logic          xsamp,
  output logic          psamp
);

  localparam logic [3:0] PAT_HEAT  = 4'b0011;
  localparam logic [3:0] PAT_LOAD  = 4'b0101;
  localparam logic [3:0] PAT_SENSE = 4'b1000;

  function automatic logic [3:0] pattern(input logic [1:0] s);
    case (s)
      2'd1:    return PAT_HEAT;
      2'd2:    return PAT_LOAD;
      2'd3:    return PAT_SENSE;
      default: return 4'b0000;
    endcase
  endfunction

  logic [1:0]    st, prev;
  logic [TW-1:0] tmr, pc, hold_sel;
  logic [CW-1:0] cyc;

  wire active = (st != 2'd0);
  wire [TW:0] tmr_x  = {1'b0, tmr};
  wire [TW:0] dead_x = (TW+1)'(dead_ticks);
  wire [TW:0] strobe_at = dead_x + (TW+1)'(settle_ticks) + (TW+1)'(1);
  wire [1:0]  nxt = (st == 2'd3) ? 2'd1 : st + 2'd1;
  wire done  = (tmr_x + (TW+1)'(1) >= {1'b0, hold_sel}) && (tmr_x >= strobe_at);
  wire pwrap = ({1'b0, pc} + (TW+1)'(1) >= {1'b0, period_ticks});

  always_comb begin
    case (st)
      2'd1:    hold_sel = hold1;
      2'd2:    hold_sel = hold2;
      default: hold_sel = hold3;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= 2'd0; prev <= 2'd0; tmr <= '0; cyc <= '0;
    end else if (!en) begin
      st <= 2'd0; prev <= 2'd0; tmr <= '0; cyc <= '0;
    end else if (!active) begin
      st <= 2'd1; prev <= 2'd0; tmr <= '0; cyc <= CW'(1);
    end else if (done) begin
      st <= nxt; prev <= st; tmr <= '0;
      if (nxt == 2'd1) cyc <= cyc + CW'(1);
    end else begin
      tmr <= tmr + TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pc <= '0;
    else if (!en || !active)   pc <= '0;
    else if (pwrap)            pc <= '0;
    else                       pc <= pc + TW'(1);
  end

  assign gate        = (tmr_x <= dead_x) ? (pattern(prev) & pattern(st)) : pattern(st);
  assign state_code  = st;
  assign cycle_cnt   = cyc;
  assign state_timer = tmr;
  assign xsamp       = active && (tmr_x == strobe_at);
  assign psamp       = active && pwrap;

  AST_STATE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code != $past(state_code) && state_code != 2'd0) |->
      (state_code == (($past(state_code) == 2'd3) ? 2'd1 : 2'($past(state_code) + 2'd1)))); // R2

  AST_BREAK_BEFORE_MAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(gate & ~$past(gate))) |-> (($past(gate) & ~gate) == 4'b0000)); // R3

  AST_STROBE_NEW_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    xsamp |-> (state_code != 2'd0 && state_code == $past(state_code))); // R4

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    xsamp |=> !xsamp); // R4

  AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 2'd1 && $past(state_code) == 2'd3) |->
      (cycle_cnt == $past(cycle_cnt) + CW'(1))); // R5

  AST_TIMER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code != $past(state_code)) |-> (state_timer == '0)); // R6

  AST_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> (gate == 4'b0000 && state_code == 2'd0 && cycle_cnt == '0)); // R8

endmodule

// File: tb/test_pwr_cycle_seq.sv
`timescale 1ns/1ps
module test_pwr_cycle_seq;
  logic        clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [31:0] hold1 = '0, hold2 = '0, hold3 = '0, period_ticks = '0;
  logic [15:0] dead_ticks = '0, settle_ticks = '0;
  logic [3:0]  gate;
  logic [1:0]  state_code;
  logic [15:0] cycle_cnt;
  logic [31:0] state_timer;
  logic        xsamp, psamp;

  int n_chk = 0, n_bad = 0;
  bit reported = 1'b0;

  always #2.5 clk = ~clk;

  pwr_cycle_seq i_pwr_cycle_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .hold1(hold1), .hold2(hold2), .hold3(hold3),
    .dead_ticks(dead_ticks), .settle_ticks(settle_ticks), .period_ticks(period_ticks),
    .gate(gate), .state_code(state_code), .cycle_cnt(cycle_cnt), .state_timer(state_timer),
    .xsamp(xsamp), .psamp(psamp));

  // dead, settle, h1, h2, h3, period | len1, len2, len3, psamp count, make offset, strobe offset
  localparam int VEC [5][12] = '{
    '{2, 3, 10, 12,  8,  7,   10, 12,  8,  4, 3, 6},
    '{0, 0,  4,  5,  6,  5,    4,  5,  6,  3, 1, 1},
    '{3, 4,  2, 20,  8,  1,    9, 20,  9, 38, 4, 8},
    '{1, 0,  1,  1,  1,  0,    3,  3,  3,  9, 2, 2},
    '{5, 2, 30,  9,  8, 11,   30,  9,  9,  4, 6, 8}
  };

  function automatic logic [3:0] bpat(input int s);
    case (s)
      1: return 4'b0011;
      2: return 4'b0101;
      3: return 4'b1000;
      default: return 4'b0000;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    end
  endtask

  task automatic load(input int v);
    dead_ticks   = 16'(VEC[v][0]);
    settle_ticks = 16'(VEC[v][1]);
    hold1 = 32'(VEC[v][2]); hold2 = 32'(VEC[v][3]); hold3 = 32'(VEC[v][4]);
    period_ticks = 32'(VEC[v][5]);
  endtask

  task automatic start();
    en = 1'b0;
    repeat (2) @(negedge clk);
    en = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_vec(input int v);
    int cur, k0, gon, str, nx, np;
    bit fin;
    load(v);
    start();
    chk(state_code == 2'd1, "R8 start state", state_code, 1);
    chk(cycle_cnt == 16'd1, "R5 first entry count", cycle_cnt, 1);
    cur = 1; k0 = 0; gon = -1; str = -1; nx = 0; np = 0; fin = 1'b0;
    for (int k = 0; k < 400 && !fin; k++) begin
      if (int'(state_code) != cur) begin
        chk(k - k0 == VEC[v][6 + cur - 1], "R2 state length", k - k0, VEC[v][6 + cur - 1]);
        chk(gon == VEC[v][10], "R1/R3 make offset", gon, VEC[v][10]);
        chk(nx == 1 && str == VEC[v][11], "R4 strobe offset", str, VEC[v][11]);
        if (cur == 3) begin
          chk(state_code == 2'd1, "R2 wrap to state 1", state_code, 1);
          chk(cycle_cnt == 16'd2, "R5 count after round", cycle_cnt, 2);
          chk(np == VEC[v][9], "R7 periodic strobes", np, VEC[v][9]);
          fin = 1'b1;
        end else begin
          chk(int'(state_code) == cur + 1, "R2 next state", state_code, cur + 1);
        end
        cur = int'(state_code); k0 = k; gon = -1; str = -1; nx = 0;
      end
      if (!fin) begin
        if (k == k0) begin
          chk(state_timer == 32'd0, "R6 timer at entry", state_timer, 0);
          // R3: overlap of old and new patterns: 0001 entering state 2, else 0000
          chk(gate == ((cur == 2) ? 4'b0001 : 4'b0000), "R3 break phase", gate,
              (cur == 2) ? 1 : 0);
        end
        if (gon < 0 && gate == bpat(cur)) gon = k - k0;
        if (xsamp) begin nx++; str = k - k0; end
        if (psamp) np++;
        @(negedge clk);
      end
    end
    chk(fin, "R2 round completed", fin, 1);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(gate == 4'b0000 && state_code == 2'd0, "R8 reset gates/state", {gate, state_code}, 0);
    chk(cycle_cnt == 16'd0 && state_timer == 32'd0, "R8 reset counters", cycle_cnt, 0);
    chk(!xsamp && !psamp, "R8 reset strobes", {xsamp, psamp}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 5; v++) run_vec(v);

    // R8: enable drop mid-state forces idle in the next cycle
    load(0);
    start();
    repeat (5) @(negedge clk);
    chk(gate == 4'b0011, "R1 state 1 pattern", gate, 3);
    en = 1'b0;
    @(negedge clk);
    chk(gate == 4'b0000 && state_code == 2'd0, "R8 enable low idle", {gate, state_code}, 0);
    chk(cycle_cnt == 16'd0 && state_timer == 32'd0, "R8 enable low counters", cycle_cnt, 0);
    chk(!xsamp && !psamp, "R8 enable low strobes", {xsamp, psamp}, 0);
    en = 1'b1;
    @(negedge clk);
    chk(state_code == 2'd1 && state_timer == 32'd0, "R8 restart in state 1", state_code, 1);
    chk(cycle_cnt == 16'd1, "R5 restart count", cycle_cnt, 1);

    // R5/R6: two full rounds with 4+5+6 cycle states
    load(1);
    start();
    repeat (3) @(negedge clk);
    chk(state_timer == 32'd3, "R6 timer increments", state_timer, 3);
    repeat (26) @(negedge clk);
    chk(state_code == 2'd3 && cycle_cnt == 16'd2, "R5 count before second wrap", cycle_cnt, 2);
    chk(gate == 4'b1000, "R1 state 3 pattern", gate, 8);
    @(negedge clk);
    chk(state_code == 2'd1 && cycle_cnt == 16'd3, "R5 count after second wrap", cycle_cnt, 3);

    summary();
    $finish;
  end
endmodule